// File: doc/BRIEF.md
# DRAM Controller Bring-Up Register Stub

This block is a small memory-mapped register file. It takes the place of a DRAM controller's setup and calibration registers while boot firmware runs. Firmware writes a start request and then polls until it sees completion. The stub answers as if every operation succeeds. A start flag reads back as set for a configurable busy window and then clears itself. A write to the impedance-calibration control register raises a completion flag in a separate status register.

The bus is a plain single-cycle register port. It carries an address, separate read and write strobes and 32-bit write data. Read data and an error pulse are both registered. Only aligned full-word accesses are modelled. A word is held and returned with bit 0 as its least significant bit, which gives little-endian byte order. No command sequencing, PHY logic, data path or memory array is present.

Top module: `dram_bringup_regs`

## Requirements
- R1: After reset, a read of the setup register returns 0x80020000, a read of the calibration control register returns 0x07B00000 and a read of the calibration status register returns 0x80000000.
- R2: The setup register is at byte offset 0x000, the calibration control register at 0x0A8 and the calibration status register at 0x0B0. Read data for a read strobed at one rising edge is on `rd_data` after that edge and reflects state before that edge. If a write happens in the same cycle, the read returns the value from before the write. In a cycle after an edge with no read, `rd_data` is zero.
- R3: Bit 31 of the setup register is the initialization start flag. After it is written as 1 at edge W, a read strobed at edge W+k returns the bit as 1 for 1 <= k <= BUSY_CYCLES and as 0 from then on. With BUSY_CYCLES = 0 it reads 0 at once.
- R4: Bit 30 of the setup register is the training start flag. It behaves exactly as in R3 and is independent of bit 31.
- R5: A write of 0 to a start flag clears it for the very next read. A second write of 1 while a flag is busy restarts its full busy window from that write.
- R6: Bits 29..0 of the setup register and all 32 bits of the calibration control register read back exactly as last written.
- R7: Every write to the calibration control register sets bit 31 of the calibration status register and leaves its bits 30..0 unchanged. A direct write to the status register stores the written value.
- R8: Reads at any offset other than the three above, including every offset at or above 0x2E4, return zero. Writes there change none of the three registers.
- R9: `err` is high for exactly the one cycle after an edge at which a read or write strobe addressed any offset other than the three above. Otherwise it is low.
- R10: A synchronous active-high reset restores all three reset values and cancels any running busy window. After reset, bit 31 of the setup register reads 1 and bit 30 reads 0, and both hold those values until they are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, zero when no read took place |
| err | output | 1 | Registered one-cycle pulse for an access outside the modelled offsets |

## Verification
Read data and the error pulse each come from a single register, so both are due one cycle after the edge that strobed the access. The bench drives each access at a falling edge and samples at the next falling edge, with accesses back to back. The k-th access after a start write therefore sees the flag as it stands k cycles later. Reads placed at k = BUSY_CYCLES and k = BUSY_CYCLES + 1 fix both edges of the busy window. Further sequences place a restart, a clearing write, a reset and a read with a simultaneous write at exact cycle offsets.

// File: rtl/bringup_pkg.sv
package bringup_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  // Offsets firmware depends on
  localparam logic [OFS_W-1:0] OFS_SETUP  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_CALCTL = 12'h0A8;
  localparam logic [OFS_W-1:0] OFS_CALSTS = 12'h0B0;

  // Reset images
  localparam logic [DATA_W-1:0] RST_SETUP  = 32'h8002_0000;
  localparam logic [DATA_W-1:0] RST_CALCTL = 32'h07B0_0000;
  localparam logic [DATA_W-1:0] RST_CALSTS = 32'h8000_0000;

  // Bit positions
  localparam int INIT_BIT  = 31;
  localparam int TRAIN_BIT = 30;
  localparam int DONE_BIT  = 31;
  localparam int NUM_FLAGS = 2;

  typedef struct packed {
    logic setup;
    logic calctl;
    logic calsts;
  } regsel_t;
endpackage

// File: rtl/bringup_decode.sv
module bringup_decode
  import bringup_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_t           sel,
  output logic              miss
);
  always_comb begin
    sel.setup  = (addr == ADDR_W'(OFS_SETUP));
    sel.calctl = (addr == ADDR_W'(OFS_CALCTL));
    sel.calsts = (addr == ADDR_W'(OFS_CALSTS));
    miss       = ~(sel.setup | sel.calctl | sel.calsts);
  end
endmodule

// File: rtl/bringup_startflag.sv
module bringup_startflag #(
  parameter int   BUSY_CYCLES = 4,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,     // write to the owning register
  input  logic set_val,  // written value of this bit
  output logic flag
);
  generate
    if (BUSY_CYCLES == 0) begin : g_instant
      // Requests finish at once: any write leaves the bit clear.
      always_ff @(posedge clk) begin
        if (rst)       flag <= RST_VAL;
        else if (load) flag <= 1'b0;
      end
    end else begin : g_timed
      localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
      logic [CNT_W-1:0] remain_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          flag     <= RST_VAL;
          remain_q <= '0;
        end else if (load) begin
          flag     <= set_val;
          remain_q <= set_val ? CNT_W'(BUSY_CYCLES) : '0;
        end else if (remain_q != '0) begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == CNT_W'(1)) flag <= 1'b0;
        end
      end

      // R3: a running window always shows the flag set
      p_window_shows_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (remain_q != '0) |-> flag);
      // R3: the last window cycle is followed by a clear flag
      p_window_end_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && remain_q == CNT_W'(1)) |=> !flag);
      // R5: a start write (also during busy) shows the flag set next cycle
      p_start_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (load && set_val) |=> (flag && remain_q == CNT_W'(BUSY_CYCLES)));
      // R5: writing zero clears at once
      p_zero_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !set_val) |=> !flag);
    end
  endgenerate
endmodule

// File: rtl/dram_bringup_regs.sv
module dram_bringup_regs
  import bringup_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              err
);
  localparam int PLAIN_W = DATA_W - NUM_FLAGS;
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = RST_SETUP[DATA_W-1 -: NUM_FLAGS];

  regsel_t sel;
  logic    miss;

  bringup_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .sel  (sel),
    .miss (miss)
  );

  logic                 setup_wr;
  logic [NUM_FLAGS-1:0] flags;   // [1] = init, [0] = training

  assign setup_wr = wr_en & sel.setup;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      bringup_startflag #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .RST_VAL     (FLAG_RST[gi])
      ) u_flag (
        .clk     (clk),
        .rst     (rst),
        .load    (setup_wr),
        .set_val (wr_data[TRAIN_BIT + gi]),
        .flag    (flags[gi])
      );
    end
  endgenerate

  logic [PLAIN_W-1:0] setup_low_q;
  logic [31:0]        calctl_q;
  logic [31:0]        calsts_q;
  logic [31:0]        rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_low_q <= RST_SETUP[PLAIN_W-1:0];
      calctl_q    <= RST_CALCTL;
      calsts_q    <= RST_CALSTS;
    end else begin
      if (setup_wr)            setup_low_q <= wr_data[PLAIN_W-1:0];
      if (wr_en && sel.calctl) calctl_q    <= wr_data;
      if (wr_en && sel.calsts)
        calsts_q <= wr_data;
      else if (wr_en && sel.calctl)
        calsts_q[DONE_BIT] <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.setup)  rd_mux = {flags, setup_low_q};
    if (sel.calctl) rd_mux = calctl_q;
    if (sel.calsts) rd_mux = calsts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      err     <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      err     <= (rd_en | wr_en) & miss;
    end
  end

  // R2: at most one register decoded per access
  p_single_select_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.setup, sel.calctl, sel.calsts}));
  // R7: a calibration-control write marks calibration done
  p_done_raised_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel.calctl) |=> calsts_q[DONE_BIT]);
  // R7: the remaining status bits are untouched by that write
  p_status_rest_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel.calctl) |=> (calsts_q[DONE_BIT-1:0] == $past(calsts_q[DONE_BIT-1:0])));
  // R8: unmodelled reads return zero
  p_miss_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && miss) |=> (rd_data == '0));
  // R8: unmodelled writes leave the stored registers alone
  p_miss_write_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && miss) |=> ($stable(calctl_q) && $stable(calsts_q) && $stable(setup_low_q)));
  // R9: error pulse follows a bad access
  p_err_on_miss_r9: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && miss) |=> err);
  // R9: no error without a bad access
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !((rd_en || wr_en) && miss) |=> !err);
endmodule

// File: tb/dram_bringup_regs_bench.sv
module dram_bringup_regs_bench;
  localparam int ADDR_W = 12;
  localparam int BUSY   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic              err;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  dram_bringup_regs #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) u_dram_bringup_regs (
    .clk (clk), .rst (rst), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
    .wr_data (wr_data), .rd_data (rd_data), .err (err)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] ofs;
    logic [31:0] data;
    logic [31:0] exp;
    logic        eerr;
    logic [3:0]  req;
  } vec_t;

  // One access per cycle; exp is rd_data one cycle later (0 when no read).
  localparam vec_t VEC [24] = '{
    '{1'b0,1'b1,12'h000,32'h0,        32'h8002_0000,1'b0,4'd1},  // R1
    '{1'b0,1'b1,12'h0A8,32'h0,        32'h07B0_0000,1'b0,4'd1},  // R1
    '{1'b0,1'b1,12'h0B0,32'h0,        32'h8000_0000,1'b0,4'd1},  // R1
    '{1'b1,1'b0,12'h000,32'hC000_1234,32'h0,        1'b0,4'd3},  // R3 R4 start both
    '{1'b0,1'b1,12'h000,32'h0,        32'hC000_1234,1'b0,4'd3},  // R3 k=1
    '{1'b0,1'b1,12'h000,32'h0,        32'hC000_1234,1'b0,4'd4},  // R4 k=2
    '{1'b0,1'b1,12'h000,32'h0,        32'hC000_1234,1'b0,4'd3},  // R3 k=3
    '{1'b0,1'b1,12'h000,32'h0,        32'hC000_1234,1'b0,4'd3},  // R3 k=4
    '{1'b0,1'b1,12'h000,32'h0,        32'h0000_1234,1'b0,4'd3},  // R3 R6 k=5 cleared
    '{1'b1,1'b0,12'h0B0,32'h0000_0055,32'h0,        1'b0,4'd7},  // R7 direct status write
    '{1'b0,1'b1,12'h0B0,32'h0,        32'h0000_0055,1'b0,4'd7},  // R7
    '{1'b1,1'b0,12'h0A8,32'h1234_5678,32'h0,        1'b0,4'd7},  // R7 cal write
    '{1'b0,1'b1,12'h0A8,32'h0,        32'h1234_5678,1'b0,4'd6},  // R6
    '{1'b0,1'b1,12'h0B0,32'h0,        32'h8000_0055,1'b0,4'd7},  // R7 done set, rest kept
    '{1'b1,1'b0,12'h2E4,32'hFFFF_FFFF,32'h0,        1'b1,4'd9},  // R9 R8
    '{1'b0,1'b1,12'h2E4,32'h0,        32'h0,        1'b1,4'd8},  // R8 R9
    '{1'b0,1'b1,12'h004,32'h0,        32'h0,        1'b1,4'd8},  // R8 unimplemented
    '{1'b1,1'b0,12'h0AC,32'hFFFF_FFFF,32'h0,        1'b1,4'd9},  // R9
    '{1'b0,1'b1,12'h0A8,32'h0,        32'h1234_5678,1'b0,4'd8},  // R8 no effect
    '{1'b0,1'b1,12'h0B0,32'h0,        32'h8000_0055,1'b0,4'd8},  // R8 no effect
    '{1'b0,1'b1,12'h000,32'h0,        32'h0000_1234,1'b0,4'd8},  // R8 no effect
    '{1'b1,1'b0,12'h000,32'h4000_0000,32'h0,        1'b0,4'd4},  // R4 training only
    '{1'b1,1'b0,12'h000,32'h0000_0000,32'h0,        1'b0,4'd5},  // R5 clear at k=1
    '{1'b0,1'b1,12'h000,32'h0,        32'h0000_0000,1'b0,4'd5}   // R5 cleared at once
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input logic act_e, input logic exp_e);
    n_vec++;
    if (act !== exp || act_e !== exp_e) begin
      n_bad++;
      $display("FAIL %s: rd_data=%08h err=%0b expected rd_data=%08h err=%0b",
               tag, act, act_e, exp, exp_e);
    end
  endtask

  // Call at a falling edge; drives one access, returns at the next falling edge.
  task automatic access(input logic w, input logic r, input logic [11:0] a,
                        input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10/R1: idle output state after reset
    check("R1 idle after reset", rd_data, 32'h0, err, 1'b0);

    for (int i = 0; i < 24; i++) begin
      access(VEC[i].wr, VEC[i].rd, VEC[i].ofs, VEC[i].data);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp, err, VEC[i].eerr);
    end

    // R5: restart during busy. Start at W, rewrite start at W+3.
    access(1'b1, 1'b0, 12'h000, 32'h8000_0000);
    access(1'b0, 1'b0, 12'h000, 32'h0);
    access(1'b0, 1'b0, 12'h000, 32'h0);
    access(1'b1, 1'b0, 12'h000, 32'h8000_0000);   // new window from here
    access(1'b0, 1'b0, 12'h000, 32'h0);            // k=1
    access(1'b0, 1'b0, 12'h000, 32'h0);            // k=2
    access(1'b0, 1'b0, 12'h000, 32'h0);            // k=3
    access(1'b0, 1'b1, 12'h000, 32'h0);            // k=4
    check("R5 restarted window still busy", rd_data, 32'h8000_0000, err, 1'b0);
    access(1'b0, 1'b1, 12'h000, 32'h0);            // k=5
    check("R5 restarted window ends", rd_data, 32'h0, err, 1'b0);

    // R2: read and write in the same cycle return the old value
    access(1'b1, 1'b1, 12'h0A8, 32'hA5A5_0F0F);
    check("R2 read before write", rd_data, 32'h1234_5678, err, 1'b0);
    access(1'b0, 1'b1, 12'h0A8, 32'h0);
    check("R2 write lands", rd_data, 32'hA5A5_0F0F, err, 1'b0);
    access(1'b0, 1'b0, 12'h0A8, 32'h0);
    check("R2 no read gives zero", rd_data, 32'h0, err, 1'b0);

    // R10: reset in the middle of a training window
    access(1'b1, 1'b0, 12'h000, 32'h4000_0001);
    rst = 1'b1;
    access(1'b0, 1'b0, 12'h000, 32'h0);
    access(1'b0, 1'b0, 12'h000, 32'h0);
    rst = 1'b0;
    access(1'b0, 1'b1, 12'h000, 32'h0);
    check("R10 setup restored", rd_data, 32'h8002_0000, err, 1'b0);
    access(1'b0, 1'b1, 12'h0A8, 32'h0);
    check("R10 calctl restored", rd_data, 32'h07B0_0000, err, 1'b0);
    access(1'b0, 1'b1, 12'h0B0, 32'h0);
    check("R10 status restored", rd_data, 32'h8000_0000, err, 1'b0);
    repeat (BUSY + 2) access(1'b0, 1'b0, 12'h000, 32'h0);
    access(1'b0, 1'b1, 12'h000, 32'h0);
    check("R10 flags hold after reset", rd_data, 32'h8002_0000, err, 1'b0);

    // R3: writing init start from its reset value with training clear
    access(1'b1, 1'b0, 12'h000, 32'h8000_0000);
    repeat (BUSY) access(1'b0, 1'b0, 12'h000, 32'h0);
    access(1'b0, 1'b1, 12'h000, 32'h0);            // k=BUSY+1
    check("R3 init done after window", rd_data, 32'h0, err, 1'b0);
    access(1'b0, 1'b0, 12'h000, 32'h0);
    check("R9 err quiet", rd_data, 32'h0, err, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule